// File: doc/BRIEF.md
# Two-Beat Coprocessor Load/Store Sequencer

This block sits between a 32-bit memory data bus and a file of sixteen 64-bit coprocessor registers. It carries out the data phase of coprocessor loads and stores. A transfer is either a single word (a 32-bit integer or a single-precision float) or a pair of words (a 64-bit integer or a double). The host core generates the addresses and raises a data-cycle strobe for each bus beat. On every beat the block answers combinationally. The answer is either "done" or "increment", meaning the host should advance the address and present another beat.

On a two-word transfer, the big-endian input sets which register half travels on the first beat. The other half follows on the second beat. A single-word load is handled by the unit selected with a type input. The integer unit sign-extends the word across the whole register. The float unit places the word in the upper half only. The register file lives inside the block, and its write port is brought out as outputs. Stores read the file in the same cycle as the beat. Register writes take effect on the clock edge that ends a load beat.

Top module: `cop_ldst_seq`

## Requirements
- R1: After reset every register holds zero and the response reads "done" (`resp_inc` = 0).
- R2: The register index is taken from instruction bits 15:12, and instruction bit 22 set selects a two-word transfer. All other instruction bits have no effect.
- R3: A cycle with `data_cyc` low answers "done", performs no register write, and restarts the beat count. The next two-word beat is therefore treated as a first beat.
- R4: On a two-word transfer the first beat answers "increment" (`resp_inc` = 1) and the second beat answers "done". A single-word beat always answers "done".
- R5: On a two-word load, the first beat writes the upper half (`wr_hi_en`=1, `wr_lo_en`=0) when `big_end` is 1, and the lower half otherwise. The second beat writes the other half.
- R6: On a two-word store, `bus_out` carries the upper half on the first beat when `big_end` is 1, and the lower half otherwise. The second beat carries the other half.
- R7: A single-word load with `is_float`=0 writes the word into bits 31:0 and copies its bit 31 into bits 63:32, with both half enables set.
- R8: A single-word load with `is_float`=1 writes the word into bits 63:32 only and leaves bits 31:0 unchanged.
- R9: A single-word store outputs bits 31:0 when `is_float`=0 and bits 63:32 when `is_float`=1.
- R10: During a two-word load, the half not written by the current beat keeps its previous value. This also holds when the transfer is cut off after its first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | 32 | Instruction word (bit 22 = two-word, bits 15:12 = register) |
| data_cyc | input | 1 | High during a data beat |
| is_load | input | 1 | 1 = load (bus to register), 0 = store |
| is_float | input | 1 | 1 = float unit, 0 = integer unit |
| big_end | input | 1 | Big-endian word order for two-word transfers |
| bus_in | input | 32 | Incoming bus word for loads |
| bus_out | output | 32 | Outgoing bus word for stores (0 otherwise) |
| resp_inc | output | 1 | 1 = increment and send another beat, 0 = done |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Register being written |
| wr_hi_en | output | 1 | Write enable for bits 63:32 |
| wr_lo_en | output | 1 | Write enable for bits 31:0 |
| wr_data | output | 64 | Write data |

## Verification
Two-word loads are swept over all sixteen registers under both endian settings. Each is read back with a two-word store using the opposite endian setting, which separates a correct half swap from a store that only mirrors the load order. Single-word loads use values with bit 31 both set and clear, so sign extension can be told apart from zero fill, and upper-only float writes from whole-register writes. Two-word loads cut off after one beat by an idle cycle show that the untouched half survives and that the beat count restarts. The instruction word carries noise in its unused bits throughout.

// File: rtl/cop_ldst_seq.sv
module cop_ldst_seq #(
  parameter int INSTR_W  = 32,
  parameter int WORD_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int IDX_LSB  = 12,
  parameter int LONG_BIT = 22
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [INSTR_W-1:0]          instr,
  input  logic                        data_cyc,
  input  logic                        is_load,
  input  logic                        is_float,
  input  logic                        big_end,
  input  logic [WORD_W-1:0]           bus_in,
  output logic [WORD_W-1:0]           bus_out,
  output logic                        resp_inc,
  output logic                        wr_en,
  output logic [$clog2(NUM_REGS)-1:0] wr_idx,
  output logic                        wr_hi_en,
  output logic                        wr_lo_en,
  output logic [2*WORD_W-1:0]         wr_data
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int REG_W = 2 * WORD_W;

  logic [REG_W-1:0] rf [NUM_REGS];
  logic             beat_q;
  logic             long_x;
  logic             hi_sel;
  logic [IDX_W-1:0] idx;
  logic             unused_instr;

  assign long_x       = instr[LONG_BIT];
  assign idx          = instr[IDX_LSB +: IDX_W];
  assign unused_instr = ^{instr[INSTR_W-1:LONG_BIT+1], instr[LONG_BIT-1:IDX_LSB+IDX_W], instr[IDX_LSB-1:0]};

  // Half selected by this beat: endian order for pairs, unit choice for singles.
  assign hi_sel   = long_x ? (big_end ^ beat_q) : is_float;

  assign resp_inc = data_cyc & long_x & ~beat_q;
  assign wr_en    = data_cyc & is_load;
  assign wr_idx   = idx;
  assign wr_hi_en = wr_en & (hi_sel | (~long_x & ~is_float));
  assign wr_lo_en = wr_en & ~hi_sel;
  assign wr_data  = (long_x | is_float) ? {bus_in, bus_in}
                                        : {{WORD_W{bus_in[WORD_W-1]}}, bus_in};
  assign bus_out  = (data_cyc & ~is_load)
                  ? (hi_sel ? rf[idx][REG_W-1:WORD_W] : rf[idx][WORD_W-1:0])
                  : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  beat_q <= 1'b0;
    else if (data_cyc && long_x) beat_q <= ~beat_q;
    else                         beat_q <= 1'b0;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rf[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        if (wr_hi_en) rf[g][REG_W-1:WORD_W] <= wr_data[REG_W-1:WORD_W];
        if (wr_lo_en) rf[g][WORD_W-1:0]     <= wr_data[WORD_W-1:0];
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !data_cyc |-> (!resp_inc && !wr_en)); // R3
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !data_cyc |=> (!(data_cyc && instr[LONG_BIT]) || resp_inc)); // R3
  AST_SECOND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cyc && resp_inc) |=> !resp_inc); // R4
  AST_FIRST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_inc && is_load) |-> (wr_hi_en == big_end)); // R5
  AST_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && instr[LONG_BIT]) |-> ($countones({wr_hi_en, wr_lo_en}) == 1)); // R10
  AST_FLOAT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_float && !instr[LONG_BIT]) |-> (wr_hi_en && !wr_lo_en)); // R8
endmodule

// File: tb/test_cop_ldst_seq.sv
module test_cop_ldst_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr;
  logic        data_cyc, is_load, is_float, big_end;
  logic [31:0] bus_in, bus_out;
  logic        resp_inc, wr_en, wr_hi_en, wr_lo_en;
  logic [3:0]  wr_idx;
  logic [63:0] wr_data;

  int errs = 0;
  int checks = 0;
  logic [63:0] m [16];

  always #4 clk = ~clk;

  cop_ldst_seq i_cop_ldst_seq (
    .clk(clk), .rst_n(rst_n), .instr(instr), .data_cyc(data_cyc),
    .is_load(is_load), .is_float(is_float), .big_end(big_end),
    .bus_in(bus_in), .bus_out(bus_out), .resp_inc(resp_inc),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi_en(wr_hi_en),
    .wr_lo_en(wr_lo_en), .wr_data(wr_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic beat(input bit ld, input bit fl, input bit lng, input bit be,
                      input logic [3:0] idx, input logic [31:0] din,
                      input bit second, input string req);
    bit hi;
    @(negedge clk);
    data_cyc = 1'b1; is_load = ld; is_float = fl; big_end = be; bus_in = din;
    instr = (32'h1A0F_0A5F & ~32'h0040_F000) | (32'(lng) << 22) | (32'(idx) << 12);
    #1;
    chk(req, 64'(resp_inc), 64'(lng && !second), "resp");
    hi = lng ? (be ^ second) : fl;
    if (ld) begin
      chk(req, 64'(wr_en), 64'd1, "wr_en");
      chk(req, 64'(wr_idx), 64'(idx), "wr_idx");
      chk(req, 64'({wr_hi_en, wr_lo_en}),
          64'(lng ? (hi ? 2'b10 : 2'b01) : (fl ? 2'b10 : 2'b11)), "halves");
    end else begin
      chk(req, 64'(bus_out), 64'(hi ? m[idx][63:32] : m[idx][31:0]), "bus_out");
    end
    @(posedge clk);
    if (ld) begin
      if (lng || fl) begin
        if (hi) m[idx][63:32] = din;
        else    m[idx][31:0]  = din;
      end else begin
        m[idx] = {{32{din[31]}}, din};
      end
    end
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    data_cyc = 1'b0;
    bus_in = 32'hDEAD_BEEF;
    #1;
    chk(req, 64'(resp_inc), 64'd0, "idle resp");
    chk(req, 64'(wr_en), 64'd0, "idle wr_en");
    @(posedge clk);
  endtask

  task automatic store_pair(input logic [3:0] idx, input bit be, input string req);
    beat(0, 0, 1, be, idx, 32'h0, 0, req);
    beat(0, 0, 1, be, idx, 32'h0, 1, req);
  endtask

  initial begin
    #(8 * 100000);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = '0;
    rst_n = 1'b0; data_cyc = 1'b0; is_load = 1'b0; is_float = 1'b0;
    big_end = 1'b0; bus_in = '0; instr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1", 64'(resp_inc), 64'd0, "reset resp");
    chk("R1", 64'(bus_out), 64'd0, "reset bus_out");
    rst_n = 1'b1;

    // R1: every register reads zero after reset
    for (int i = 0; i < 16; i++) store_pair(4'(i), 1'b0, "R1");

    // R5 / R6: pair loads under both orders, read back with the opposite order
    for (int be = 0; be < 2; be++) begin
      for (int i = 0; i < 16; i++) begin
        beat(1, 0, 1, 1'(be), 4'(i), 32'h9E37_79B9 * (i + 1) + be, 0, "R5");
        beat(1, 0, 1, 1'(be), 4'(i), 32'h7F4A_7C15 ^ (i << 8) ^ be, 1, "R5");
      end
      for (int i = 0; i < 16; i++) store_pair(4'(i), 1'(~be), "R6");
      idle("R3");
    end

    // R7 / R9: single integer loads, sign bit both set and clear
    for (int i = 0; i < 16; i++) begin
      beat(1, 0, 0, 1'(i & 1), 4'(i), (i % 2 == 0) ? (32'h8000_0000 | (i * 32'h0101_0101)) : (i * 32'h0011_2233), 0, "R7");
      beat(0, 0, 0, 1'b0, 4'(i), 32'h0, 0, "R9");
      beat(0, 1, 0, 1'b1, 4'(i), 32'h0, 0, "R9");
    end

    // R8: single float loads touch only the upper half
    for (int i = 0; i < 16; i++) begin
      beat(1, 1, 0, 1'b0, 4'(i), 32'h3F80_0000 + i, 0, "R8");
      store_pair(4'(i), 1'b1, "R8");
    end

    // R10 / R3: pair load cut off after one beat, with load still selected while idle
    for (int i = 0; i < 8; i++) begin
      beat(1, 0, 1, 1'(i & 1), 4'(i), 32'hC0DE_0000 + i, 0, "R10");
      idle("R3");
      store_pair(4'(i), 1'b0, "R10");
    end

    // R2: final sweep with noisy instruction bits, single stores of both units
    for (int i = 0; i < 16; i++) begin
      beat(0, 1, 0, 1'b0, 4'(i), 32'h0, 0, "R2");
      beat(0, 0, 0, 1'b1, 4'(i), 32'h0, 0, "R2");
    end
    idle("R3");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule